// File: doc/BRIEF.md
# Counter-rotating frame sequence decoupler

This block separates a stationary-frame voltage vector (alpha, beta) into its positive-sequence and negative-sequence parts. It belongs in the front end of a grid synchronisation loop. For each sample it takes the vector and the current phase estimate. It projects the vector onto two frames that rotate in opposite directions, one at +angle and one at -angle. In each frame the twice-frequency ripple that the opposite sequence causes is then removed. The removed term is the other frame's low-pass-filtered d/q pair, rotated by twice the angle. The feedback always uses the filtered values from the previous sample, so the two frames never form a combinational loop.

Four first-order IIR filters smooth the decoupled values. Once they settle, the filtered positive-frame d value equals the positive-sequence amplitude and the filtered negative-frame d value equals the negative-sequence amplitude. The decoupled positive-frame q value is the error signal for an external PI phase loop. That loop and the three-to-two phase transform are outside this block.

A four-state sequencer processes one sample at a time. In `ST_IDLE` the block waits. A high `in_valid` latches the sample and moves to `ST_ROT`, which registers the two projections. `ST_ROT` always moves to `ST_DEC`, which registers the decoupled values. `ST_DEC` always moves to `ST_FILT`, which updates the filters and raises `out_valid`. `ST_FILT` always returns to `ST_IDLE`.

Top module: `sdn_decouple`

## Requirements
- R1: After reset, all eight data outputs are zero and `out_valid` is low.
- R2: A sample is accepted on a rising edge at which `in_valid` is high and the block is idle. `out_valid` goes high after the fourth rising edge, counting the accepting edge as the first. It stays high for exactly one cycle, and the outputs hold the new results while it is high.
- R3: An `in_valid` that arrives while a sample is still being processed is ignored. It produces no extra `out_valid` pulse and does not alter the results of the sample in flight.
- R4: `theta_i` is an unsigned angle in which 2^AW codes make one full turn, code 0 is zero and increasing codes turn counterclockwise (code 64 is a quarter turn at AW=8). The doubled angle wraps modulo a full turn.
- R5: The positive frame values are d = a*cos + b*sin and q = b*cos - a*sin. Here a and b are the inputs and the angle is theta. A unit coefficient reproduces its operand exactly.
- R6: The negative frame values are d = a*cos - b*sin and q = a*sin + b*cos.
- R7: The positive frame is corrected using the negative frame's previous filtered values Dn and Qn and the doubled angle. Its d loses (Dn*cos2 + Qn*sin2) and its q loses (Qn*cos2 - Dn*sin2).
- R8: The negative frame is corrected using the positive frame's previous filtered values Dp and Qp. Its d loses (Dp*cos2 - Qp*sin2) and its q loses (Dp*sin2 + Qp*cos2).
- R9: Each filter keeps an accumulator with FK fraction bits that resets to zero. Per sample it adds floor((x*2^FK - acc) / 2^FK). Its output is floor(acc / 2^FK).
- R10: Every projection and every decoupled value is clamped to the signed DW-bit range [-2^(DW-1), 2^(DW-1)-1].
- R11: The input is a positive sequence of amplitude 4000 plus a negative sequence of amplitude 1000, sampled at quarter-turn steps. After 200 samples the filtered positive d is within 4 of 4000, the filtered negative d is within 4 of 1000, and both filtered q values are within 4 of 0.
- R12: While the block is idle, all eight data outputs keep their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| alpha_i | input | DW | Stationary-frame alpha component, signed |
| beta_i | input | DW | Stationary-frame beta component, signed |
| theta_i | input | AW | Phase estimate, unsigned turn fraction |
| out_valid | output | 1 | One-cycle pulse when results are updated |
| pos_d | output | DW | Decoupled positive-frame d |
| pos_q | output | DW | Decoupled positive-frame q (phase error) |
| neg_d | output | DW | Decoupled negative-frame d |
| neg_q | output | DW | Decoupled negative-frame q |
| pos_d_flt | output | DW | Filtered positive-frame d |
| pos_q_flt | output | DW | Filtered positive-frame q |
| neg_d_flt | output | DW | Filtered negative-frame d |
| neg_q_flt | output | DW | Filtered negative-frame q |

## Verification
The sample is accepted on the edge after `in_valid` is driven. The projections register one edge later and the decoupled values two edges later. The filters and `out_valid` update on the fourth edge. The bench therefore reads every result on the fourth falling edge after that edge and checks that `out_valid` is low on the falling edges before and after it. Angles are kept to quarter turns, plus one eighth-turn sample with zero input, so the trigonometric factors are exactly 0 or ±1. This lets the bench model predict every output to the bit. The bench also samples the filtered amplitudes against the true sequence amplitudes after the settling run.

// File: rtl/sdn_pkg.sv
`timescale 1ns/1ps
package sdn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROT,
        ST_DEC,
        ST_FILT
    } sdn_state_e;

    localparam int NUM_CH = 4;
    localparam int CH_PD  = 0;
    localparam int CH_PQ  = 1;
    localparam int CH_ND  = 2;
    localparam int CH_NQ  = 3;
endpackage

// File: rtl/sdn_sincos.sv
`timescale 1ns/1ps
module sdn_sincos #(
    parameter int AW = 8,
    parameter int CW = 16
) (
    input  logic [AW-1:0]        ang_i,
    output logic signed [CW-1:0] sin_o,
    output logic signed [CW-1:0] cos_o
);
    localparam int QB = AW - 2;
    localparam int QN = 2 ** QB;
    localparam int HN = 2 * QN;
    localparam longint ONE = longint'(1) << (CW - 2);
    localparam logic [AW-1:0] QTR = AW'(QN);
    localparam logic [QB:0]   QNV = (QB + 1)'(QN);

    logic signed [CW-1:0] qtab [QN+1];

    // rational approximation, exact at zero and at a quarter turn
    function automatic logic signed [CW-1:0] tab_val(input int i);
        longint num, den, v;
        num = 64'(16) * longint'(i) * longint'(HN - i);
        den = 64'(5) * longint'(HN) * longint'(HN) - 64'(4) * longint'(i) * longint'(HN - i);
        v   = (ONE * num) / den;
        return v[CW-1:0];
    endfunction

    for (genvar g = 0; g <= QN; g++) begin : g_tab
        assign qtab[g] = tab_val(g);
    end

    function automatic logic signed [CW-1:0] pick(input logic [AW-1:0] a);
        logic [QB:0] ix;
        logic signed [CW-1:0] m;
        ix = a[AW-2] ? (QNV - {1'b0, a[QB-1:0]}) : {1'b0, a[QB-1:0]};
        m  = qtab[ix];
        return a[AW-1] ? -m : m;
    endfunction

    always_comb begin
        sin_o = pick(ang_i);
        cos_o = pick(ang_i + QTR);
    end
endmodule

// File: rtl/sdn_lpf.sv
`timescale 1ns/1ps
module sdn_lpf #(
    parameter int W = 16,
    parameter int K = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic signed [W-1:0] x_i,
    output logic signed [W-1:0] y_o
);
    localparam int AW = W + K;

    logic signed [AW-1:0] acc_q;
    logic signed [AW:0]   diff;
    logic signed [AW:0]   step;

    always_comb begin
        diff = {x_i[W-1], x_i, {K{1'b0}}} - {acc_q[AW-1], acc_q};
        step = diff >>> K;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= acc_q + step[AW-1:0];
        end
    end

    assign y_o = acc_q[AW-1:K];

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(y_o));
endmodule

// File: rtl/sdn_decouple.sv
`timescale 1ns/1ps
module sdn_decouple
    import sdn_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int AW = 8,
    parameter int FK = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] alpha_i,
    input  logic signed [DW-1:0] beta_i,
    input  logic [AW-1:0]        theta_i,
    output logic                 out_valid,
    output logic signed [DW-1:0] pos_d,
    output logic signed [DW-1:0] pos_q,
    output logic signed [DW-1:0] neg_d,
    output logic signed [DW-1:0] neg_q,
    output logic signed [DW-1:0] pos_d_flt,
    output logic signed [DW-1:0] pos_q_flt,
    output logic signed [DW-1:0] neg_d_flt,
    output logic signed [DW-1:0] neg_q_flt
);
    localparam int FB = CW - 2;
    localparam int XW = DW + CW + 2;
    localparam logic signed [XW-1:0] XMAX = {{(XW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [XW-1:0] XMIN = {{(XW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    function automatic logic signed [XW-1:0] ext(input logic signed [DW-1:0] v);
        return {{(XW-DW){v[DW-1]}}, v};
    endfunction

    function automatic logic signed [XW-1:0] extc(input logic signed [CW-1:0] v);
        return {{(XW-CW){v[CW-1]}}, v};
    endfunction

    function automatic logic signed [DW-1:0] sat(input logic signed [XW-1:0] v);
        if (v > XMAX)      return XMAX[DW-1:0];
        else if (v < XMIN) return XMIN[DW-1:0];
        else               return v[DW-1:0];
    endfunction

    sdn_state_e state_q, state_d;

    logic signed [DW-1:0] alpha_q, beta_q;
    logic [AW-1:0]        theta_q;
    logic [AW-1:0]        theta2;
    logic signed [CW-1:0] s1, c1, s2, c2;
    logic signed [DW-1:0] rot_c [NUM_CH];
    logic signed [DW-1:0] rot_q [NUM_CH];
    logic signed [DW-1:0] dec_c [NUM_CH];
    logic signed [DW-1:0] dec_q [NUM_CH];
    logic signed [DW-1:0] flt   [NUM_CH];
    logic                 out_valid_q;
    logic                 flt_en;

    // doubled angle wraps by dropping the top bit
    assign theta2 = {theta_q[AW-2:0], 1'b0};

    sdn_sincos #(.AW(AW), .CW(CW)) u_trig_1 (.ang_i(theta_q), .sin_o(s1), .cos_o(c1));
    sdn_sincos #(.AW(AW), .CW(CW)) u_trig_2 (.ang_i(theta2),  .sin_o(s2), .cos_o(c2));

    // projections onto the two counter-rotating frames
    always_comb begin
        rot_c[CH_PD] = sat((ext(alpha_q) * extc(c1) + ext(beta_q)  * extc(s1)) >>> FB);
        rot_c[CH_PQ] = sat((ext(beta_q)  * extc(c1) - ext(alpha_q) * extc(s1)) >>> FB);
        rot_c[CH_ND] = sat((ext(alpha_q) * extc(c1) - ext(beta_q)  * extc(s1)) >>> FB);
        rot_c[CH_NQ] = sat((ext(alpha_q) * extc(s1) + ext(beta_q)  * extc(c1)) >>> FB);
    end

    // cross-coupling removal with the previous sample's filtered values
    always_comb begin
        dec_c[CH_PD] = sat(ext(rot_q[CH_PD]) -
            ((ext(flt[CH_ND]) * extc(c2) + ext(flt[CH_NQ]) * extc(s2)) >>> FB));
        dec_c[CH_PQ] = sat(ext(rot_q[CH_PQ]) -
            ((ext(flt[CH_NQ]) * extc(c2) - ext(flt[CH_ND]) * extc(s2)) >>> FB));
        dec_c[CH_ND] = sat(ext(rot_q[CH_ND]) -
            ((ext(flt[CH_PD]) * extc(c2) - ext(flt[CH_PQ]) * extc(s2)) >>> FB));
        dec_c[CH_NQ] = sat(ext(rot_q[CH_NQ]) -
            ((ext(flt[CH_PD]) * extc(s2) + ext(flt[CH_PQ]) * extc(c2)) >>> FB));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_ROT;
            ST_ROT:  state_d = ST_DEC;
            ST_DEC:  state_d = ST_FILT;
            ST_FILT: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alpha_q <= '0;
            beta_q  <= '0;
            theta_q <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                rot_q[i] <= '0;
                dec_q[i] <= '0;
            end
        end else begin
            if (state_q == ST_IDLE && in_valid) begin
                alpha_q <= alpha_i;
                beta_q  <= beta_i;
                theta_q <= theta_i;
            end
            if (state_q == ST_ROT) rot_q <= rot_c;
            if (state_q == ST_DEC) dec_q <= dec_c;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid_q <= 1'b0;
        else        out_valid_q <= (state_q == ST_FILT);
    end

    assign flt_en = (state_q == ST_FILT);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lpf
        sdn_lpf #(.W(DW), .K(FK)) u_lpf (
            .clk  (clk),
            .rst_n(rst_n),
            .en_i (flt_en),
            .x_i  (dec_q[g]),
            .y_o  (flt[g])
        );
    end

    assign out_valid = out_valid_q;
    assign pos_d     = dec_q[CH_PD];
    assign pos_q     = dec_q[CH_PQ];
    assign neg_d     = dec_q[CH_ND];
    assign neg_q     = dec_q[CH_NQ];
    assign pos_d_flt = flt[CH_PD];
    assign pos_q_flt = flt[CH_PQ];
    assign neg_d_flt = flt[CH_ND];
    assign neg_q_flt = flt[CH_NQ];

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid) |-> ##4 out_valid_q);

    // R2
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_q |=> !out_valid_q);

    // R3
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(alpha_q) && $stable(beta_q) && $stable(theta_q)));

    // R4
    quarter_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (theta_q[AW-3:0] == '0) |-> (c1 == '0 || s1 == '0));
endmodule

// File: tb/test_sdn_decouple.sv
`timescale 1ns/1ps
module test_sdn_decouple;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int FK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] alpha = '0;
    logic signed [DW-1:0] beta = '0;
    logic [AW-1:0] theta = '0;

    logic out_valid;
    logic signed [DW-1:0] pos_d, pos_q, neg_d, neg_q;
    logic signed [DW-1:0] pos_d_flt, pos_q_flt, neg_d_flt, neg_q_flt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    longint macc [4];
    longint exp_v [4];
    longint exp_f [4];

    always #10 clk = ~clk;

    sdn_decouple #(.DW(DW), .CW(16), .AW(AW), .FK(FK)) i_sdn_decouple (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .alpha_i(alpha), .beta_i(beta), .theta_i(theta),
        .out_valid(out_valid),
        .pos_d(pos_d), .pos_q(pos_q), .neg_d(neg_d), .neg_q(neg_q),
        .pos_d_flt(pos_d_flt), .pos_q_flt(pos_q_flt),
        .neg_d_flt(neg_d_flt), .neg_q_flt(neg_q_flt)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input string what, input longint act,
                              input longint exp, input longint tol);
        longint d;
        n_chk++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (+-%0d)", req, what, act, exp, tol);
        end
    endtask

    function automatic longint msat(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic trig_q(input int ang, output longint c, output longint s);
        case (ang)
            0:       begin c = 1;  s = 0;  end
            64:      begin c = 0;  s = 1;  end
            128:     begin c = -1; s = 0;  end
            192:     begin c = 0;  s = -1; end
            default: begin c = 0;  s = 0;  end // only used with zero inputs
        endcase
    endtask

    // requirement-level model of one sample (R5..R10)
    task automatic model(input longint a, input longint b, input int th);
        longint c, s, c2, s2;
        longint fl [4];
        longint r [4];
        trig_q(th, c, s);
        trig_q((2 * th) % 256, c2, s2);
        for (int i = 0; i < 4; i++) fl[i] = macc[i] >>> FK;
        r[0] = msat(a * c + b * s);
        r[1] = msat(b * c - a * s);
        r[2] = msat(a * c - b * s);
        r[3] = msat(a * s + b * c);
        exp_v[0] = msat(r[0] - (fl[2] * c2 + fl[3] * s2));
        exp_v[1] = msat(r[1] - (fl[3] * c2 - fl[2] * s2));
        exp_v[2] = msat(r[2] - (fl[0] * c2 - fl[1] * s2));
        exp_v[3] = msat(r[3] - (fl[0] * s2 + fl[1] * c2));
        for (int i = 0; i < 4; i++) begin
            macc[i] = macc[i] + (((exp_v[i] <<< FK) - macc[i]) >>> FK);
            exp_f[i] = macc[i] >>> FK;
        end
    endtask

    task automatic reset_dut();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) macc[i] = 0;
    endtask

    task automatic drive(input longint a, input longint b, input int th);
        alpha = DW'(a);
        beta = DW'(b);
        theta = AW'(th);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic compare_all(input string req);
        check(req, "out_valid", out_valid, 1);
        check(req, "pos_d", pos_d, exp_v[0]);
        check(req, "pos_q", pos_q, exp_v[1]);
        check(req, "neg_d", neg_d, exp_v[2]);
        check(req, "neg_q", neg_q, exp_v[3]);
        check(req, "pos_d_flt", pos_d_flt, exp_f[0]);
        check(req, "pos_q_flt", pos_q_flt, exp_f[1]);
        check(req, "neg_d_flt", neg_d_flt, exp_f[2]);
        check(req, "neg_q_flt", neg_q_flt, exp_f[3]);
    endtask

    task automatic run_sample(input longint a, input longint b, input int th, input string req);
        model(a, b, th);
        drive(a, b, th);
        repeat (3) @(negedge clk);
        compare_all(req);
        @(negedge clk);
        check("R2", "out_valid after pulse", out_valid, 0);
    endtask

    task automatic t_reset();
        reset_dut();
        check("R1", "out_valid", out_valid, 0);
        check("R1", "pos_d", pos_d, 0);
        check("R1", "pos_q", pos_q, 0);
        check("R1", "neg_d", neg_d, 0);
        check("R1", "neg_q", neg_q, 0);
        check("R1", "pos_d_flt", pos_d_flt, 0);
        check("R1", "pos_q_flt", pos_q_flt, 0);
        check("R1", "neg_d_flt", neg_d_flt, 0);
        check("R1", "neg_q_flt", neg_q_flt, 0);
    endtask

    task automatic t_latency();
        reset_dut();
        model(1000, 0, 0);
        drive(1000, 0, 0);
        check("R2", "out_valid edge 1", out_valid, 0);
        @(negedge clk);
        check("R2", "out_valid edge 2", out_valid, 0);
        @(negedge clk);
        check("R2", "out_valid edge 3", out_valid, 0);
        @(negedge clk);
        compare_all("R2");
        check("R2", "pos_d_flt value", pos_d_flt, 125);
        @(negedge clk);
        check("R2", "out_valid one cycle", out_valid, 0);
    endtask

    task automatic t_project();
        reset_dut();
        run_sample(300, 500, 64, "R4 R5 R6");
        run_sample(-700, 250, 128, "R4 R5 R6");
        run_sample(1200, -900, 192, "R4 R5 R6");
        run_sample(-450, -800, 0, "R4 R5 R6");
    endtask

    task automatic t_cross();
        reset_dut();
        run_sample(800, -1600, 0, "R7 R8");
        run_sample(0, 0, 32, "R7 R8");
        check("R7", "pos_d sin2 term", pos_d, 200);
        check("R7", "pos_q sin2 term", pos_q, 100);
        check("R8", "neg_d sin2 term", neg_d, -200);
        check("R8", "neg_q sin2 term", neg_q, -100);
        run_sample(600, 200, 64, "R7 R8");
    endtask

    task automatic t_busy();
        int extra;
        reset_dut();
        model(700, -300, 128);
        alpha = 700;
        beta = -300;
        theta = 128;
        in_valid = 1'b1;
        @(negedge clk);
        alpha = -5000;
        beta = 4000;
        theta = 64;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        compare_all("R3");
        extra = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (out_valid) extra++;
        end
        check("R3", "extra out_valid pulses", extra, 0);
    endtask

    task automatic t_hold();
        reset_dut();
        run_sample(1500, -2500, 0, "R12");
        for (int i = 0; i < 8; i++) begin
            alpha = DW'(i * 999 - 3000);
            beta = DW'(2000 - i * 777);
            theta = AW'(i * 37);
            @(negedge clk);
        end
        check("R12", "out_valid idle", out_valid, 0);
        check("R12", "pos_d held", pos_d, exp_v[0]);
        check("R12", "pos_q held", pos_q, exp_v[1]);
        check("R12", "neg_d held", neg_d, exp_v[2]);
        check("R12", "neg_q held", neg_q, exp_v[3]);
        check("R12", "pos_d_flt held", pos_d_flt, exp_f[0]);
        check("R12", "pos_q_flt held", pos_q_flt, exp_f[1]);
        check("R12", "neg_d_flt held", neg_d_flt, exp_f[2]);
        check("R12", "neg_q_flt held", neg_q_flt, exp_f[3]);
    endtask

    task automatic t_sat();
        reset_dut();
        run_sample(-32768, 0, 64, "R10");
        check("R10", "pos_q clamp high", pos_q, 32767);
        check("R10", "neg_q at min", neg_q, -32768);
        reset_dut();
        run_sample(32767, 0, 0, "R10");
        run_sample(-32768, 0, 0, "R10");
        check("R10", "pos_d clamp low", pos_d, -32768);
        check("R10", "neg_d clamp low", neg_d, -32768);
    endtask

    task automatic t_converge();
        longint c, s;
        reset_dut();
        for (int i = 0; i < 200; i++) begin
            trig_q((i % 4) * 64, c, s);
            run_sample(5000 * c, 3000 * s, (i % 4) * 64, "R11 R9");
        end
        check_near("R11", "pos_d_flt amplitude", pos_d_flt, 4000, 4);
        check_near("R11", "neg_d_flt amplitude", neg_d_flt, 1000, 4);
        check_near("R11", "pos_q_flt", pos_q_flt, 0, 4);
        check_near("R11", "neg_q_flt", neg_q_flt, 0, 4);
        check_near("R11", "pos_d ripple removed", pos_d, 4000, 4);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) macc[i] = 0;
        t_reset();
        t_latency();
        t_project();
        t_cross();
        t_busy();
        t_hold();
        t_sat();
        t_converge();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule